// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects seven interrupt sources for an 8-bit processor core: four active-low external pins, two timer overflow pulses and a serial port flag. It keeps a pending flag for each source and gates each flag with a per-source enable and a global enable. It then chooses one request by priority level and by a fixed polling order, and presents it to the core with its vector address. The core answers with a one-cycle acknowledge when it enters the handler. It sends a one-cycle return strobe when the handler finishes.

There are two priority levels. A high-level request may interrupt a low-level handler. A request at the level already in service waits for the return strobe. Configuration comes through a small register port with four byte-wide registers. One of them, the control register for external inputs 2 and 3, also takes single-bit writes. That register can be read back, and it shows the live pending flags of those two inputs.

Top module: `irq_arbiter7`

## Requirements
- R1: After reset every configuration bit is 0, irq_req is 0, irq_vec is 0 and xctl_q reads 00H.
- R2: Source index 0..6 stands for external 0, timer 0, external 1, timer 1, serial, external 2 and external 3. Their vectors are 03H, 0BH, 13H, 1BH, 23H, 33H and 3BH. irq_vec is 0 whenever irq_req is 0.
- R3: Among pending requests at the same level, the lowest source index is presented.
- R4: A request whose priority bit is 1 is presented before any request whose priority bit is 0, whatever the polling order.
- R5: Register map, selected by reg_sel:
  - reg_sel 0 holds the global enable in bit 7, and the enables of sources 0..4 in bits 0..4.
  - reg_sel 1 holds the priority bits of sources 0..4 in bits 0..4.
  - reg_sel 3 holds the edge-mode bits of external 0 and external 1 in bits 0 and 1.
  - reg_sel 2 holds, from bit 7 down to bit 0: priority of ext 3, enable of ext 3, flag of ext 3, mode of ext 3, priority of ext 2, enable of ext 2, flag of ext 2, mode of ext 2.
  - A write with bit_wr changes only bit bit_idx of register 2, and xctl_q shows that register.
- R6: A mode bit of 1 selects falling-edge detection. A 1 then 0 on two successive input samples sets the flag, and the acknowledge of that source clears it. While the pin stays low, no new request follows. A pin change reaches irq_req on the third rising clock edge.
- R7: A mode bit of 0 selects low-level detection. The flag follows the inverted pin, and neither the acknowledge nor a software write changes it.
- R8: A source is requested only when its flag, its enable bit and the global enable are all 1.
- R9: A high-level request is presented during a low-level handler. A request at a level that is in service, or below it, waits until the return strobe.
- R10: A timer overflow pulse sets that timer's flag, which reaches irq_req on the second rising edge, and the acknowledge clears it. The serial flag follows the serial input and is not cleared by the acknowledge.
- R11: After an acknowledge, irq_req is 0 in the next cycle. An acknowledge while irq_req is 0 has no effect.
- R12: In edge mode, software may write the flag bit of external 2 or 3 through register 2 to set or clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_n | input | 4 | External interrupt pins 0..3, active low |
| tmr_ovf | input | 2 | Timer 0 and timer 1 overflow pulses |
| ser_flag | input | 1 | Serial port interrupt flag (level) |
| reg_wr | input | 1 | Byte write strobe |
| reg_sel | input | 2 | Register select for byte writes |
| reg_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Single-bit write strobe for register 2 |
| bit_idx | input | 3 | Bit position for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| xctl_q | output | 8 | Read-back of register 2 with live flags |
| irq_ack | input | 1 | Handler entry acknowledge |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the presented request |

## Verification
The assertions take four things for granted about the core:
- it raises irq_ack only while irq_req is high;
- it never raises irq_ack and irq_ret in the same cycle;
- it sends a return only while a handler is active;
- each timer overflow lasts a single cycle.

The directed tasks pulse acknowledge and return one cycle at a time, and only in those situations. The one exception is a deliberate acknowledge with no request pending, used to check R11. That case touches no in-service state, so the assertions still hold.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 7;
  localparam int NEXT      = 4;
  localparam int NCLASSIC  = 5;

  typedef enum logic [1:0] {K_EXT, K_PULSE, K_LEVEL} src_kind_e;

  function automatic src_kind_e kind_of(input int idx);
    if (idx == 1 || idx == 3) return K_PULSE;
    if (idx == 4) return K_LEVEL;
    return K_EXT;
  endfunction

  // external pin number of an external source
  function automatic int ext_of(input int idx);
    case (idx)
      2: return 1;
      5: return 2;
      6: return 3;
      default: return 0;
    endcase
  endfunction

  // timer number of a pulse source
  function automatic int tmr_of(input int idx);
    return (idx == 3) ? 1 : 0;
  endfunction

  // vector slot NCLASSIC is unused, later sources move up one slot
  function automatic int vec_of(input int idx, input int base, input int step);
    int slot;
    slot = (idx < NCLASSIC) ? idx : idx + 1;
    return base + step * slot;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NSRC = irq_pkg::NSRC,
  parameter int NEXT = irq_pkg::NEXT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [1:0]      reg_sel,
  input  logic [7:0]      reg_wdata,
  input  logic            bit_wr,
  input  logic [2:0]      bit_idx,
  input  logic            bit_val,
  output logic            glb_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_pri,
  output logic [NEXT-1:0] ext_edge,
  output logic [7:0]      xcfg,
  output logic [NEXT-1:0] flag_wr,
  output logic [NEXT-1:0] flag_wval
);
  localparam int NC      = irq_pkg::NCLASSIC;
  localparam int G_BIT   = 7;
  localparam int B_MODE2 = 0;
  localparam int B_FLG2  = 1;
  localparam int B_EN2   = 2;
  localparam int B_PRI2  = 3;
  localparam int B_MODE3 = 4;
  localparam int B_FLG3  = 5;
  localparam int B_EN3   = 6;
  localparam int B_PRI3  = 7;
  localparam logic [7:0] FLG_MASK = 8'((1 << B_FLG2) | (1 << B_FLG3));

  localparam logic [1:0] SEL_EN   = 2'd0;
  localparam logic [1:0] SEL_PRI  = 2'd1;
  localparam logic [1:0] SEL_XCTL = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  logic [NC-1:0] en_q, pri_q;
  logic          g_q;
  logic [1:0]    mode_q;
  logic [7:0]    x_q, x_d;

  always_comb begin
    x_d = x_q;
    if (reg_wr && reg_sel == SEL_XCTL)
      x_d = reg_wdata & ~FLG_MASK;
    else if (bit_wr && !FLG_MASK[bit_idx])
      x_d[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pri_q  <= '0;
      g_q    <= 1'b0;
      mode_q <= '0;
      x_q    <= '0;
    end else begin
      x_q <= x_d;
      if (reg_wr) begin
        case (reg_sel)
          SEL_EN:   begin en_q <= reg_wdata[NC-1:0]; g_q <= reg_wdata[G_BIT]; end
          SEL_PRI:  pri_q  <= reg_wdata[NC-1:0];
          SEL_MODE: mode_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    flag_wr   = '0;
    flag_wval = '0;
    if (reg_wr && reg_sel == SEL_XCTL) begin
      flag_wr[2]   = 1'b1;
      flag_wr[3]   = 1'b1;
      flag_wval[2] = reg_wdata[B_FLG2];
      flag_wval[3] = reg_wdata[B_FLG3];
    end else if (bit_wr && bit_idx == 3'(B_FLG2)) begin
      flag_wr[2]   = 1'b1;
      flag_wval[2] = bit_val;
    end else if (bit_wr && bit_idx == 3'(B_FLG3)) begin
      flag_wr[3]   = 1'b1;
      flag_wval[3] = bit_val;
    end
  end

  assign glb_en   = g_q;
  assign src_en   = {x_q[B_EN3], x_q[B_EN2], en_q};
  assign src_pri  = {x_q[B_PRI3], x_q[B_PRI2], pri_q};
  assign ext_edge = {x_q[B_MODE3], x_q[B_MODE2], mode_q};
  assign xcfg     = x_q;

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (en_q == '0 && pri_q == '0 && !g_q && mode_q == '0 && x_q == '0));

  p_bit_write_local_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_wr && !reg_wr) |=> ((x_q ^ $past(x_q)) & ~(8'd1 << $past(bit_idx))) == 8'd0);
endmodule

// File: rtl/irq_flag.sv
module irq_flag #(
  parameter irq_pkg::src_kind_e KIND = irq_pkg::K_EXT
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic edge_mode,
  input  logic ack,
  input  logic sw_wr,
  input  logic sw_val,
  output logic flag
);
  generate
    if (KIND == irq_pkg::K_EXT) begin : g_ext
      logic s1, s2, fall;
      assign fall = s2 & ~s1;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1   <= 1'b1;
          s2   <= 1'b1;
          flag <= 1'b0;
        end else begin
          s1 <= raw;
          s2 <= s1;
          if (!edge_mode)  flag <= ~s1;
          else if (fall)   flag <= 1'b1;
          else if (ack)    flag <= 1'b0;
          else if (sw_wr)  flag <= sw_val;
        end
      end

      p_edge_set_needs_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && $past(edge_mode) && $rose(flag)) |-> $past(fall || sw_wr));
      p_edge_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && ack && !fall) |=> !flag);
      p_level_ack_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && ack && !s1) |=> flag);
    end else if (KIND == irq_pkg::K_PULSE) begin : g_pulse
      logic unused_pulse;
      assign unused_pulse = ^{edge_mode, sw_wr, sw_val};
      always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (raw)  flag <= 1'b1;
        else if (ack)  flag <= 1'b0;
      end

      p_pulse_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && !raw) |=> !flag);
    end else begin : g_level
      logic unused_level;
      assign unused_level = ^{edge_mode, sw_wr, sw_val, ack};
      always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= raw;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic hi_busy,
  output logic lo_busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_busy <= 1'b0;
      lo_busy <= 1'b0;
    end else if (take) begin
      if (take_hi) hi_busy <= 1'b1;
      else         lo_busy <= 1'b1;
    end else if (ret) begin
      if (hi_busy) hi_busy <= 1'b0;
      else         lo_busy <= 1'b0;
    end
  end

  p_hi_entry_on_take_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_busy) |-> $past(take && take_hi));
  p_lo_entry_on_take_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_busy) |-> $past(take && !take_hi));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC     = irq_pkg::NSRC,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int IDX_W   = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  act,
  input  logic [NSRC-1:0]  pri,
  input  logic             hi_busy,
  input  logic             lo_busy,
  input  logic             ack,
  output logic             req_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             hi_q
);
  logic [NSRC-1:0]  hi_mask, lo_mask, mask;
  logic             use_hi;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    hi_mask  = act & pri & {NSRC{~hi_busy}};
    lo_mask  = act & ~pri & {NSRC{~(hi_busy | lo_busy)}};
    use_hi   = |hi_mask;
    mask     = use_hi ? hi_mask : lo_mask;
    pick_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (mask[i]) pick_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
      idx_q <= '0;
      hi_q  <= 1'b0;
    end else if (ack && req_q) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= |mask;
      vec_q <= (|mask) ? VEC_W'(irq_pkg::vec_of(int'(pick_idx), VEC_BASE, VEC_STEP)) : '0;
      idx_q <= pick_idx;
      hi_q  <= use_hi;
    end
  end

  p_ack_drops_req_r11: assert property (@(posedge clk) disable iff (rst)
    (ack && req_q) |=> !req_q);
  p_hi_not_reentered_r9: assert property (@(posedge clk) disable iff (rst)
    (req_q && hi_q) |-> !hi_busy);
  p_lo_waits_r9: assert property (@(posedge clk) disable iff (rst)
    (req_q && !hi_q) |-> !(hi_busy || lo_busy));
  p_idle_vec_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !req_q |-> vec_q == '0);
endmodule

// File: rtl/irq_arbiter7.sv
module irq_arbiter7 #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ext_n,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_flag,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic             bit_wr,
  input  logic [2:0]       bit_idx,
  input  logic             bit_val,
  output logic [7:0]       xctl_q,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int NSRC  = irq_pkg::NSRC;
  localparam int NEXT  = irq_pkg::NEXT;
  localparam int IDX_W = $clog2(NSRC);

  logic            glb_en;
  logic [NSRC-1:0] src_en, src_pri, flags, act, ack_oh;
  logic [NEXT-1:0] ext_edge, flag_wr, flag_wval;
  logic [7:0]      xcfg;
  logic            hi_busy, lo_busy, take, hi_q;
  logic [IDX_W-1:0] idx_q;

  irq_regs #(.NSRC(NSRC), .NEXT(NEXT)) u_regs (
    .clk, .rst, .reg_wr, .reg_sel, .reg_wdata, .bit_wr, .bit_idx, .bit_val,
    .glb_en, .src_en, .src_pri, .ext_edge, .xcfg, .flag_wr, .flag_wval
  );

  assign take = irq_ack && irq_req;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam irq_pkg::src_kind_e KND = irq_pkg::kind_of(i);
      localparam int EX = irq_pkg::ext_of(i);
      localparam int TM = irq_pkg::tmr_of(i);
      logic raw_i;
      if (KND == irq_pkg::K_EXT)        begin : g_r assign raw_i = ext_n[EX];   end
      else if (KND == irq_pkg::K_PULSE) begin : g_r assign raw_i = tmr_ovf[TM]; end
      else                              begin : g_r assign raw_i = ser_flag;    end

      assign ack_oh[i] = take && (idx_q == IDX_W'(i));

      irq_flag #(.KIND(KND)) u_flag (
        .clk, .rst, .raw(raw_i), .edge_mode(ext_edge[EX]), .ack(ack_oh[i]),
        .sw_wr(flag_wr[EX]), .sw_val(flag_wval[EX]), .flag(flags[i])
      );
    end
  endgenerate

  assign act = flags & src_en & {NSRC{glb_en}};

  irq_nest u_nest (
    .clk, .rst, .take, .take_hi(hi_q), .ret(irq_ret), .hi_busy, .lo_busy
  );

  irq_pick #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_pick (
    .clk, .rst, .act, .pri(src_pri), .hi_busy, .lo_busy, .ack(irq_ack),
    .req_q(irq_req), .vec_q(irq_vec), .idx_q, .hi_q
  );

  assign xctl_q = {xcfg[7:6], flags[6], xcfg[4:2], flags[5], xcfg[0]};

  p_gate_global_r8: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq_req);
  p_onehot_ack_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_oh));
endmodule

// File: tb/irq_arbiter7_test.sv
module irq_arbiter7_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ext_n = 4'hF;
  logic [1:0] tmr_ovf = 2'b00;
  logic       ser_flag = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       bit_wr = 1'b0;
  logic [2:0] bit_idx = 3'd0;
  logic       bit_val = 1'b0;
  logic [7:0] xctl_q;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vec;

  int n_checks = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  irq_arbiter7 uut (
    .clk, .rst, .ext_n, .tmr_ovf, .ser_flag, .reg_wr, .reg_sel, .reg_wdata,
    .bit_wr, .bit_idx, .bit_val, .xctl_q, .irq_ack, .irq_ret, .irq_req, .irq_vec
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] idx, input logic v);
    bit_idx = idx; bit_val = v; bit_wr = 1'b1;
    @(negedge clk);
    bit_wr = 1'b0;
  endtask

  task automatic pulse_ack;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_ret;
    irq_ret = 1'b1; @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 req after reset", irq_req, 0);
    check("R1 vec after reset", irq_vec, 0);
    check("R1 xctl after reset", xctl_q, 8'h00);
  endtask

  task automatic t_bits;
    wr_bit(3'd2, 1'b1);
    check("R5 bit write enable ext2", xctl_q, 8'h04);
    wr_reg(2'd2, 8'hC8);
    check("R5 byte write", xctl_q, 8'hC8);
    wr_bit(3'd6, 1'b0);
    check("R5 bit clear only bit 6", xctl_q, 8'h88);
    wr_bit(3'd5, 1'b1);
    check("R7 flag write ignored in level mode", xctl_q, 8'h88);
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_edge_ext2;
    wr_reg(2'd2, 8'h01);
    ext_n[2] = 1'b0;
    wait_n(3);
    check("R6 edge sets flag ext2", xctl_q, 8'h03);
    check("R8 no req without enable", irq_req, 0);
    wr_bit(3'd2, 1'b1);
    wait_n(2);
    check("R8 no req without global", irq_req, 0);
    wr_reg(2'd0, 8'h80);
    wait_n(1);
    check("R8 req with all enables", irq_req, 1);
    check("R2 vector ext2", irq_vec, 8'h33);
    pulse_ack;
    check("R11 req drops after ack", irq_req, 0);
    check("R6 ack clears ext2 flag", xctl_q, 8'h05);
    pulse_ret;
    ext_n[2] = 1'b1;
    wait_n(2);
    check("R6 no re-request while held", irq_req, 0);
    wr_bit(3'd1, 1'b1);
    wait_n(1);
    check("R12 software set of flag", irq_req, 1);
    check("R12 software set vector", irq_vec, 8'h33);
    pulse_ack;
    pulse_ret;
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h00);
  endtask

  task automatic t_level_ext3;
    wr_reg(2'd0, 8'h80);
    wr_bit(3'd6, 1'b1);
    ext_n[3] = 1'b0;
    wait_n(3);
    check("R7 level req ext3", irq_req, 1);
    check("R2 vector ext3", irq_vec, 8'h3B);
    check("R7 flag visible ext3", xctl_q, 8'h60);
    pulse_ack;
    check("R7 flag kept after ack", xctl_q, 8'h60);
    pulse_ret;
    wait_n(1);
    check("R7 level re-request", irq_req, 1);
    pulse_ack;
    ext_n[3] = 1'b1;
    pulse_ret;
    wait_n(2);
    check("R7 released pin no req", irq_req, 0);
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_order;
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h9F);
    tmr_ovf = 2'b11; ser_flag = 1'b1;
    wait_n(1);
    tmr_ovf = 2'b00;
    wait_n(1);
    check("R3 timer0 first", irq_vec, 8'h0B);
    pulse_ack;
    wait_n(1);
    check("R9 same level waits", irq_req, 0);
    pulse_ret;
    wait_n(1);
    check("R3 timer1 second", irq_vec, 8'h1B);
    pulse_ack; pulse_ret;
    wait_n(1);
    check("R3 serial third", irq_vec, 8'h23);
    pulse_ack; pulse_ret;
    wait_n(1);
    check("R10 serial flag held", irq_vec, 8'h23);
    pulse_ack;
    ser_flag = 1'b0;
    pulse_ret;
    wait_n(1);
    check("R10 timer flags cleared, serial low", irq_req, 0);
  endtask

  task automatic t_prio_nest;
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd1, 8'h04);
    wr_reg(2'd0, 8'h85);
    ext_n[1:0] = 2'b00;
    wait_n(3);
    check("R4 high level beats order", irq_vec, 8'h13);
    pulse_ack;
    ext_n[1] = 1'b1;
    wait_n(2);
    check("R9 low blocked by high handler", irq_req, 0);
    pulse_ret;
    wait_n(1);
    check("R9 low after return", irq_vec, 8'h03);
    pulse_ack;
    wait_n(1);
    check("R9 low handler blocks low", irq_req, 0);
    ext_n[1] = 1'b0;
    wait_n(3);
    check("R9 high preempts low", irq_vec, 8'h13);
    pulse_ack;
    ext_n[1:0] = 2'b11;
    wait_n(2);
    pulse_ret; pulse_ret;
    wait_n(2);
    check("R9 all handlers done", irq_req, 0);
    wr_reg(2'd1, 8'h00);
  endtask

  task automatic t_ack_idle;
    wr_reg(2'd0, 8'h82);
    pulse_ack;
    wait_n(1);
    tmr_ovf[0] = 1'b1;
    wait_n(1);
    tmr_ovf[0] = 1'b0;
    wait_n(1);
    check("R11 stray ack ignored", irq_vec, 8'h0B);
    pulse_ack; pulse_ret;
  endtask

  task automatic t_edge_ext0;
    wr_reg(2'd3, 8'h01);
    wr_reg(2'd0, 8'h81);
    ext_n[0] = 1'b0;
    wait_n(3);
    check("R6 edge ext0 req", irq_vec, 8'h03);
    pulse_ack; pulse_ret;
    wait_n(2);
    check("R6 held low no new req", irq_req, 0);
    ext_n[0] = 1'b1;
    wait_n(2);
    ext_n[0] = 1'b0;
    wait_n(2);
    check("R6 timing not before third edge", irq_req, 0);
    wait_n(1);
    check("R6 second edge req", irq_req, 1);
    pulse_ack; pulse_ret;
    ext_n[0] = 1'b1;
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset;
    t_bits;
    t_edge_ext2;
    t_level_ext3;
    t_order;
    t_prio_nest;
    t_ack_idle;
    t_edge_ext0;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule